// File: doc/BRIEF.md
# Masked Interrupt Concentrator with Channel Steering

This block gathers a wide set of level-sensitive interrupt requests and folds them into a few combined lines. Each input passes through an enable bit. Software can also raise any input by writing a force bit. The result is visible as 32-bit status words. Inputs are bundled into groups of 64 (the last group may hold only 32). Each group produces one combined level. A per-group disable bit can silence that level, while a separate master-status view still reports it.

The combined levels are routed to one destination channel, chosen by a one-hot control word. Every group line is replicated per channel, and only the selected channel's copies can go high. Software reaches all of this through a word-addressed, single-cycle read/write bus. Read data returns one cycle after the request.

Register words are numbered from the top of the input range downwards. With R = NUM_IRQ/32 words per bank, input i sits in word R-1-(i/32) at bit i mod 32. The word map is as follows:
- Word 0: the channel control word.
- Words 1..R: the enable words.
- Words R+1..2R: the force words.
- Words 2R+1..3R: the status words.
- Word 3R+1: the group-disable word.
- Word 3R+2: the master-status word.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset every output line is low, and the control, enable, force and group-disable words all read zero.
- R2: Enable word n (word address 1+n) is read/write and covers inputs 32(R-1-n) to 32(R-1-n)+31, with bit b controlling input 32(R-1-n)+b; a 1 enables the input.
- R3: Status word n (word address 2R+1+n), bit b, reads (level OR force) AND enable of input 32(R-1-n)+b, using the input level sampled on the previous clock edge; writes to status words change nothing.
- R4: Force word n (word address R+1+n) is read/write, and a force bit makes its input pending exactly as a high level would, still subject to the enable bit.
- R5: The line for group g (inputs 64g to 64g+63) is high when at least one status bit in that group is set and the group is not disabled; an input change appears on the line two clock edges after it is applied, and the line stays high as long as the enabled level stays high.
- R6: Master-status word (word address 3R+2) bit g reads the OR of group g's status bits, regardless of the group-disable bit.
- R7: The control word (word address 0) holds a one-hot channel choice. A write with exactly one bit set, within the NUM_CHAN low bits, is accepted; any other write value is ignored. Output bit c*NUM_GRP+g carries group g's line when channel c is chosen, and is low otherwise.
- R8: Reads of unmapped word addresses return zero, and writes to them change no register.
- R9: Read data appears on the cycle after the read request and holds until the next read.
- R10: The group-disable word (word address 3R+1) keeps only its NUM_GRP low bits. Bit g set forces group g's line low one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt inputs |
| bus_en_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | NUM_CHAN*NUM_GRP | Steered group lines, bit c*NUM_GRP+g |

## Verification
The hardest state to reach is one where a group's combined level, its disable bit and the reversed word numbering all interact. In that state the master-status word must still report a group that the output hides, and a pending bit must land in the right status word even though word order runs against input order. The stimulus builds enable words that differ from word to word, so a mapping error changes which inputs pass. It then drives single inputs at word and group edges (0, 63, 64, 127), sets one group's disable bit while both groups are pending, and uses force bits on both an enabled and a disabled word.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  typedef enum logic [2:0] {
    REG_CTRL,
    REG_EN,
    REG_FORCE,
    REG_STAT,
    REG_GDIS,
    REG_MSTAT,
    REG_NONE
  } reg_region_e;

  typedef struct packed {
    reg_region_e region;
    logic [5:0]  idx;
  } reg_sel_t;

  // Word map: 0 control, 1..R enable, R+1..2R force, 2R+1..3R status,
  // 3R+1 group disable, 3R+2 master status.
  function automatic reg_sel_t decode_word(input int unsigned w, input int unsigned r);
    reg_sel_t s;
    s.region = REG_NONE;
    s.idx    = '0;
    if (w == 0) begin
      s.region = REG_CTRL;
    end else if (w <= r) begin
      s.region = REG_EN;
      s.idx    = 6'(w - 1);
    end else if (w <= 2 * r) begin
      s.region = REG_FORCE;
      s.idx    = 6'(w - 1 - r);
    end else if (w <= 3 * r) begin
      s.region = REG_STAT;
      s.idx    = 6'(w - 1 - 2 * r);
    end else if (w == 3 * r + 1) begin
      s.region = REG_GDIS;
    end else if (w == 3 * r + 2) begin
      s.region = REG_MSTAT;
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_steer_regfile.sv
module irq_steer_regfile
  import irq_steer_pkg::*;
#(
  parameter int NUM_IRQ  = 128,
  parameter int NUM_CHAN = 4,
  parameter int NUM_GRP  = 2,
  parameter int ADDR_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  input  logic [NUM_IRQ-1:0]  status_i,
  input  logic [NUM_GRP-1:0]  mstat_i,
  output logic [NUM_IRQ-1:0]  en_o,
  output logic [NUM_IRQ-1:0]  force_o,
  output logic [NUM_CHAN-1:0] ctrl_o,
  output logic [NUM_GRP-1:0]  gdis_o,
  output logic [31:0]         rdata_o
);

  localparam int WORDS = NUM_IRQ / 32;
  localparam logic [31:0] CHAN_FIELD = (32'd1 << NUM_CHAN) - 32'd1;

  logic [WORDS-1:0][31:0] en_q;
  logic [WORDS-1:0][31:0] force_q;
  logic [WORDS-1:0][31:0] stat_w;
  logic [NUM_CHAN-1:0]    ctrl_q;
  logic [NUM_GRP-1:0]     gdis_q;
  logic [31:0]            rdata_q;
  logic [31:0]            rd_val;
  reg_sel_t               sel;
  logic                   wr_req;
  logic                   rd_req;
  logic                   ctrl_ok;

  assign sel     = decode_word(32'(bus_addr_i), WORDS);
  assign wr_req  = bus_en_i && bus_we_i;
  assign rd_req  = bus_en_i && !bus_we_i;
  assign ctrl_ok = ($countones(bus_wdata_i) == 1) && ((bus_wdata_i & ~CHAN_FIELD) == 32'd0);

  // Reversed numbering: word n holds the inputs of block WORDS-1-n.
  for (genvar n = 0; n < WORDS; n++) begin : g_map
    assign en_o[32*(WORDS-1-n) +: 32]    = en_q[n];
    assign force_o[32*(WORDS-1-n) +: 32] = force_q[n];
    assign stat_w[n]                     = status_i[32*(WORDS-1-n) +: 32];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q    <= '0;
      force_q <= '0;
      ctrl_q  <= '0;
      gdis_q  <= '0;
    end else if (wr_req) begin
      case (sel.region)
        REG_CTRL: if (ctrl_ok) ctrl_q <= bus_wdata_i[NUM_CHAN-1:0];
        REG_EN: begin
          for (int n = 0; n < WORDS; n++)
            if (sel.idx == 6'(n)) en_q[n] <= bus_wdata_i;
        end
        REG_FORCE: begin
          for (int n = 0; n < WORDS; n++)
            if (sel.idx == 6'(n)) force_q[n] <= bus_wdata_i;
        end
        REG_GDIS: gdis_q <= bus_wdata_i[NUM_GRP-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (sel.region)
      REG_CTRL: rd_val[NUM_CHAN-1:0] = ctrl_q;
      REG_EN: begin
        for (int n = 0; n < WORDS; n++)
          if (sel.idx == 6'(n)) rd_val = en_q[n];
      end
      REG_FORCE: begin
        for (int n = 0; n < WORDS; n++)
          if (sel.idx == 6'(n)) rd_val = force_q[n];
      end
      REG_STAT: begin
        for (int n = 0; n < WORDS; n++)
          if (sel.idx == 6'(n)) rd_val = stat_w[n];
      end
      REG_GDIS:  rd_val[NUM_GRP-1:0] = gdis_q;
      REG_MSTAT: rd_val[NUM_GRP-1:0] = mstat_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_val;
  end

  assign ctrl_o  = ctrl_q;
  assign gdis_o  = gdis_q;
  assign rdata_o = rdata_q;

  p_ctrl_onehot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(ctrl_q));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_req && sel.region == REG_NONE) |=> (rdata_q == 32'd0));

  p_stat_write_ignored_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_req && sel.region == REG_STAT) |=> ($stable(en_q) && $stable(force_q)
                                            && $stable(ctrl_q) && $stable(gdis_q)));

  p_read_holds_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rd_req) |=> $stable(rdata_q));

endmodule

// File: rtl/irq_steer_group.sv
module irq_steer_group #(
  parameter int GRP_W    = 64,
  parameter int NUM_CHAN = 4
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [GRP_W-1:0]    pend_i,
  input  logic                gdis_i,
  input  logic [NUM_CHAN-1:0] chan_i,
  output logic                any_o,
  output logic [NUM_CHAN-1:0] line_o
);

  logic [NUM_CHAN-1:0] line_q;

  assign any_o = |pend_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)                  line_q <= '0;
    else if (any_o && !gdis_i)  line_q <= chan_i;
    else                        line_q <= '0;
  end

  assign line_o = line_q;

  p_line_needs_pending_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (|line_q) |-> $past(any_o && !gdis_i));

  p_gdis_silences_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    gdis_i |=> (line_q == '0));

  p_line_one_channel_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(line_q));

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
  import irq_steer_pkg::*;
#(
  parameter int NUM_IRQ  = 128,
  parameter int NUM_CHAN = 4,
  parameter int ADDR_W   = 6,
  parameter int NUM_GRP  = (NUM_IRQ + 63) / 64
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NUM_IRQ-1:0]          irq_i,
  input  logic                        bus_en_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic [NUM_CHAN*NUM_GRP-1:0] irq_o
);

  logic [NUM_IRQ-1:0]  irq_q;
  logic [NUM_IRQ-1:0]  en;
  logic [NUM_IRQ-1:0]  force_bits;
  logic [NUM_IRQ-1:0]  status;
  logic [NUM_CHAN-1:0] ctrl;
  logic [NUM_GRP-1:0]  gdis;
  logic [NUM_GRP-1:0]  mstat;

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= '0;
    else       irq_q <= irq_i;
  end

  assign status = (irq_q | force_bits) & en;

  irq_steer_regfile #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CHAN(NUM_CHAN),
    .NUM_GRP (NUM_GRP),
    .ADDR_W  (ADDR_W)
  ) regs_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .status_i   (status),
    .mstat_i    (mstat),
    .en_o       (en),
    .force_o    (force_bits),
    .ctrl_o     (ctrl),
    .gdis_o     (gdis),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = 64 * g;
    localparam int GW = (NUM_IRQ - LO > 64) ? 64 : (NUM_IRQ - LO);
    logic [NUM_CHAN-1:0] line;

    irq_steer_group #(
      .GRP_W   (GW),
      .NUM_CHAN(NUM_CHAN)
    ) grp_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .pend_i(status[LO +: GW]),
      .gdis_i(gdis[g]),
      .chan_i(ctrl),
      .any_o (mstat[g]),
      .line_o(line)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      assign irq_o[c*NUM_GRP+g] = line[c];
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (irq_o == '0));

  p_no_line_without_chan_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(ctrl) == '0) |-> (irq_o == '0));

endmodule

// File: tb/irq_steer_agg_tb_top.sv
`timescale 1ns/1ps
module irq_steer_agg_tb_top;

  localparam int NI = 128;
  localparam int NC = 4;
  localparam int NG = 2;
  localparam int AW = 6;
  localparam int OW = NC * NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq = '0;
  logic          en  = 1'b0;
  logic          we  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [OW-1:0] irq_out;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_steer_agg #(.NUM_IRQ(NI), .NUM_CHAN(NC), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .irq_i(irq),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq_out)
  );

  // Word addresses for R = 4
  localparam logic [AW-1:0] A_CTRL = 6'd0;
  localparam logic [AW-1:0] A_EN0  = 6'd1;
  localparam logic [AW-1:0] A_FRC0 = 6'd5;
  localparam logic [AW-1:0] A_ST0  = 6'd9;
  localparam logic [AW-1:0] A_GDIS = 6'd13;
  localparam logic [AW-1:0] A_MST  = 6'd14;

  localparam logic [NI-1:0] ONE = 128'd1;
  localparam logic [NI-1:0] VEC_IRQ [8] = '{
    128'd0, ONE, ONE << 8, ONE << 63, ONE << 64, ONE << 127,
    (ONE << 5) | (ONE << 70), (ONE << 62) | (ONE << 100)
  };
  localparam logic [1:0] VEC_GRP [8] = '{2'b00, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b11, 2'b00};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    en = 1'b0;
  endtask

  task automatic drive_irq(input logic [NI-1:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 out", 32'(irq_out), 32'd0);
    bus_read(A_CTRL, rd);      check("R1 ctrl", rd, 32'd0);
    bus_read(A_EN0 + 3, rd);   check("R1 en3", rd, 32'd0);
    bus_read(A_GDIS, rd);      check("R1 gdis", rd, 32'd0);

    // R7 one-hot control, invalid writes ignored
    bus_write(A_CTRL, 32'h2);  bus_read(A_CTRL, rd); check("R7 ctrl ok", rd, 32'h2);
    bus_write(A_CTRL, 32'h6);  bus_read(A_CTRL, rd); check("R7 two bits", rd, 32'h2);
    bus_write(A_CTRL, 32'h0);  bus_read(A_CTRL, rd); check("R7 zero", rd, 32'h2);
    bus_write(A_CTRL, 32'h10); bus_read(A_CTRL, rd); check("R7 out of field", rd, 32'h2);

    // R2 enable words, reversed numbering
    bus_write(A_EN0 + 0, 32'h0000_0000); // inputs 96..127
    bus_write(A_EN0 + 1, 32'hFFFF_FFFF); // inputs 64..95
    bus_write(A_EN0 + 2, 32'h8000_0000); // inputs 32..63
    bus_write(A_EN0 + 3, 32'h0000_00FF); // inputs 0..31
    bus_read(A_EN0 + 3, rd); check("R2 en3 readback", rd, 32'h0000_00FF);
    bus_read(A_EN0 + 2, rd); check("R2 en2 readback", rd, 32'h8000_0000);

    // Vector table: R5 group lines on channel 1, R3 status word 3
    for (int k = 0; k < 8; k++) begin
      drive_irq(VEC_IRQ[k]);
      check("R5 vector line", 32'(irq_out), 32'(VEC_GRP[k]) << NG);
      bus_read(A_ST0 + 3, rd);
      check("R3 vector status", rd, VEC_IRQ[k][31:0] & 32'h0000_00FF);
    end

    // R5 latency: two edges from input to line
    drive_irq('0);
    @(negedge clk); irq = ONE << 64;
    @(negedge clk); check("R5 one edge", 32'(irq_out), 32'd0);
    @(negedge clk); check("R5 two edges", 32'(irq_out), 32'h8);
    drive_irq('0);
    check("R5 drop", 32'(irq_out), 32'd0);

    // R4 force bits
    bus_write(A_FRC0 + 1, 32'h8);
    @(negedge clk); check("R4 forced line", 32'(irq_out), 32'h8);
    bus_read(A_ST0 + 1, rd); check("R4 forced status", rd, 32'h8);
    bus_read(A_FRC0 + 1, rd); check("R4 force readback", rd, 32'h8);
    bus_write(A_FRC0 + 1, 32'h0);
    bus_write(A_FRC0 + 0, 32'h1);
    @(negedge clk); check("R4 masked force line", 32'(irq_out), 32'd0);
    bus_read(A_ST0 + 0, rd); check("R4 masked force status", rd, 32'd0);
    bus_write(A_FRC0 + 0, 32'h0);

    // R3 status writes ignored
    bus_write(A_ST0 + 3, 32'hFFFF_FFFF);
    @(negedge clk); check("R3 status write line", 32'(irq_out), 32'd0);
    bus_read(A_ST0 + 3, rd); check("R3 status write", rd, 32'd0);
    bus_read(A_EN0 + 3, rd); check("R3 enable untouched", rd, 32'h0000_00FF);

    // R10 / R6 group disable and master status
    drive_irq(ONE | (ONE << 64));
    check("R5 both groups", 32'(irq_out), 32'hC);
    bus_write(A_GDIS, 32'h1);
    @(negedge clk); check("R10 group0 off", 32'(irq_out), 32'h8);
    bus_read(A_MST, rd);  check("R6 mstat", rd, 32'h3);
    bus_read(A_GDIS, rd); check("R10 gdis readback", rd, 32'h1);
    bus_write(A_GDIS, 32'hFFFF_FFFF);
    @(negedge clk); check("R10 all off", 32'(irq_out), 32'd0);
    bus_read(A_GDIS, rd); check("R10 width", rd, 32'h3);
    bus_read(A_MST, rd);  check("R6 mstat ungated", rd, 32'h3);
    bus_write(A_GDIS, 32'h0);

    // R7 steering to channel 0
    bus_write(A_CTRL, 32'h1);
    @(negedge clk); check("R7 chan0", 32'(irq_out), 32'h3);

    // R8 unmapped
    bus_read(6'd20, rd); check("R8 unmapped read", rd, 32'd0);
    bus_read(6'd15, rd); check("R8 first unmapped", rd, 32'd0);
    bus_write(6'd15, 32'hFFFF_FFFF);
    bus_read(A_CTRL, rd); check("R8 unmapped write", rd, 32'h1);

    // R9 read data holds without a new read
    repeat (3) @(negedge clk);
    check("R9 hold", rdata, 32'h1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 out after reset", 32'(irq_out), 32'd0);
    bus_read(A_EN0 + 3, rd); check("R1 en cleared", rd, 32'd0);
    bus_read(A_CTRL, rd);    check("R1 ctrl cleared", rd, 32'd0);
    @(negedge clk); check("R1 out stays low", 32'(irq_out), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule